// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the fetch address of a processor core whose instructions are all 32 bits wide. Each cycle it looks at the instruction word that instruction memory returns for the current address, together with the result of an equality compare between two register operands and the value read for the first source register. From these it picks the address to fetch on the following cycle. It also raises a request to write a return address into the link register when a call is decoded.

The unit handles straight-line flow, a branch taken on equal operands, a branch taken on unequal operands, an absolute jump within the current 256 MB region, the same jump with a return-address write, and a jump to an address held in a register. A mode input selects how redirects take effect. In immediate mode a taken redirect reaches the fetch address on the next clock. In delayed mode, the word after any control transfer is always fetched. The redirect target is held in a pending register and is applied one cycle later.

The control part is a two-state machine. In state `ST_RUN` the unit fetches normally and decodes control transfers. In state `ST_SLOT` the current word is the delay-slot instruction, and the held target is loaded next. The transitions are:
- `RUN->SLOT`: a taken transfer is decoded while delayed mode is on.
- `SLOT->RUN`: always, one cycle later.
- `RUN->RUN`: every other case.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset sets the fetch address `pc` to 0 and discards any pending redirect, so the first fetch after reset is followed by address 4.
- R2: Any word that is not a control transfer advances `pc` by 4. This covers every opcode (bits 31:26) other than 2, 3, 4 and 5, and opcode 0 with any function field (bits 5:0) other than 8.
- R3: Opcode 4 is taken when `ops_equal` is 1. Its target is pc+4 plus the sign-extended 16-bit field (bits 15:0) shifted left by 2. When not taken, the next address is pc+4.
- R4: Opcode 5 uses the same target arithmetic as R3 and is taken when `ops_equal` is 0.
- R5: Opcode 2 always jumps. Its target is pc[31:28] followed by instruction bits 25:0, followed by two zero bits.
- R6: Opcode 3 jumps like R5. In the same cycle it asserts `link_we` with `link_data` = pc+4, and `link_reg` reads 31.
- R7: Opcode 0 with function field 8 always jumps to `rs_value`.
- R8: With `slot_mode` = 0, a taken transfer sets `pc` to the target at the very next clock edge.
- R9: With `slot_mode` = 1, a taken transfer is followed by a fetch at pc+4 (the slot). At the clock edge after that, `pc` is set to the target.
- R10: A control-transfer word fetched in the delay slot has no effect: neither a redirect nor a link write.
- R11: Once a redirect is pending, it completes even if `slot_mode` drops during the slot cycle.
- R12: `next_pc` always equals the value `pc` takes at the next clock edge when reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_mode | input | 1 | 1 selects delayed redirects with one slot |
| instr | input | 32 | Instruction word fetched at `pc` |
| ops_equal | input | 1 | 1 when the two compared register operands are equal |
| rs_value | input | 32 | Contents of the first source register |
| pc | output | 32 | Current fetch address |
| next_pc | output | 32 | Fetch address for the next cycle |
| link_we | output | 1 | Request to write the return address |
| link_data | output | 32 | Return address (pc+4) |
| link_reg | output | 5 | Destination register number for the return address |

## Verification
The hardest case to reach from the ports is a pending redirect that meets something unusual during its slot cycle. Examples are a second jump sitting in the slot, the mode input dropping to zero, and a reset arriving before the held target is applied. The vector table reaches the first two by putting the chosen word, or the mode change, on the cycle right after a taken transfer in delayed mode. A directed sequence then asserts reset exactly in the slot cycle, and checks that the fetch after reset advances by 4 instead of going to the stale target.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int XLEN      = 32;
    localparam int OP_W      = 6;
    localparam int FN_W      = 6;
    localparam int OFS_W     = 16;
    localparam int IDX_W     = 26;
    localparam int REG_W     = 5;
    localparam int WORD_SH   = 2;
    localparam int REGION_W  = XLEN - IDX_W - WORD_SH;
    localparam int STEP      = 1 << WORD_SH;

    localparam logic [OP_W-1:0] OPC_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0] OPC_JUMP    = 6'd2;
    localparam logic [OP_W-1:0] OPC_CALL    = 6'd3;
    localparam logic [OP_W-1:0] OPC_BR_EQ   = 6'd4;
    localparam logic [OP_W-1:0] OPC_BR_NE   = 6'd5;
    localparam logic [FN_W-1:0] FN_REG_JUMP = 6'd8;

    typedef enum logic [2:0] {
        XF_NONE,
        XF_BR_EQ,
        XF_BR_NE,
        XF_JUMP,
        XF_CALL,
        XF_REG
    } xfer_e;

    typedef enum logic {
        ST_RUN,
        ST_SLOT
    } fsm_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    input  logic            ops_equal,
    output xfer_e           kind,
    output logic            taken
);
    always_comb begin
        kind = XF_NONE;
        unique case (opcode)
            OPC_BR_EQ:   kind = XF_BR_EQ;
            OPC_BR_NE:   kind = XF_BR_NE;
            OPC_JUMP:    kind = XF_JUMP;
            OPC_CALL:    kind = XF_CALL;
            OPC_SPECIAL: kind = (funct == FN_REG_JUMP) ? XF_REG : XF_NONE;
            default:     kind = XF_NONE;
        endcase
    end

    always_comb begin
        unique case (kind)
            XF_BR_EQ: taken = ops_equal;
            XF_BR_NE: taken = !ops_equal;
            XF_JUMP,
            XF_CALL,
            XF_REG:   taken = 1'b1;
            default:  taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  logic [XLEN-1:0]  pc,
    input  logic [OFS_W-1:0] offset,
    input  logic [IDX_W-1:0] index,
    input  logic [XLEN-1:0]  rs_value,
    input  xfer_e            kind,
    output logic [XLEN-1:0]  pc_plus4,
    output logic [XLEN-1:0]  target
);
    localparam int EXT_W = XLEN - OFS_W - WORD_SH;

    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] abs_tgt;

    assign pc_plus4 = pc + XLEN'(STEP);
    assign rel_tgt  = pc_plus4 + {{EXT_W{offset[OFS_W-1]}}, offset, {WORD_SH{1'b0}}};
    assign abs_tgt  = {pc[XLEN-1 -: REGION_W], index, {WORD_SH{1'b0}}};

    always_comb begin
        unique case (kind)
            XF_BR_EQ, XF_BR_NE: target = rel_tgt;
            XF_JUMP, XF_CALL:   target = abs_tgt;
            XF_REG:             target = rs_value;
            default:            target = pc_plus4;
        endcase
    end
endmodule

// File: rtl/npc_ctrl.sv
module npc_ctrl
    import npc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            slot_mode,
    input  logic            taken,
    input  logic [XLEN-1:0] target,
    input  logic [XLEN-1:0] pc_plus4,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] next_pc,
    output fsm_e            state_q,
    output logic [XLEN-1:0] pend_q,
    output logic            xfer_ok
);
    fsm_e            state_d;
    logic [XLEN-1:0] pend_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            pend_q  <= '0;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            pc_q    <= next_pc;
        end
    end

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        next_pc = pc_plus4;
        xfer_ok = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                xfer_ok = 1'b1;
                if (taken && slot_mode) begin
                    state_d = ST_SLOT;
                    pend_d  = target;
                end else if (taken) begin
                    next_pc = target;
                end
            end
            ST_SLOT: begin
                state_d = ST_RUN;
                next_pc = pend_q;
            end
            default: state_d = ST_RUN;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int LINK_REG = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_mode,
    input  logic [XLEN-1:0]  instr,
    input  logic             ops_equal,
    input  logic [XLEN-1:0]  rs_value,
    output logic [XLEN-1:0]  pc,
    output logic [XLEN-1:0]  next_pc,
    output logic             link_we,
    output logic [XLEN-1:0]  link_data,
    output logic [REG_W-1:0] link_reg
);
    xfer_e           kind;
    logic            taken;
    logic            xfer_ok;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] pend_q;
    fsm_e            state_q;

    npc_decode u_dec (
        .opcode    (instr[XLEN-1 -: OP_W]),
        .funct     (instr[FN_W-1:0]),
        .ops_equal (ops_equal),
        .kind      (kind),
        .taken     (taken)
    );

    npc_target u_tgt (
        .pc       (pc),
        .offset   (instr[OFS_W-1:0]),
        .index    (instr[IDX_W-1:0]),
        .rs_value (rs_value),
        .kind     (kind),
        .pc_plus4 (pc_plus4),
        .target   (target)
    );

    npc_ctrl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .slot_mode (slot_mode),
        .taken     (taken),
        .target    (target),
        .pc_plus4  (pc_plus4),
        .pc_q      (pc),
        .next_pc   (next_pc),
        .state_q   (state_q),
        .pend_q    (pend_q),
        .xfer_ok   (xfer_ok)
    );

    assign link_we   = (kind == XF_CALL) && xfer_ok;
    assign link_data = pc_plus4;
    assign link_reg  = REG_W'(LINK_REG);
endmodule

// File: rtl/npc_checks.sv
module npc_checks
    import npc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            slot_mode,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] next_pc,
    input  logic            link_we,
    input  fsm_e            state_q,
    input  logic [XLEN-1:0] pend_q,
    input  logic            taken,
    input  logic [XLEN-1:0] target
);
    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> pc == '0); // R1

    AST_IMM_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && taken && !slot_mode) |=> pc == $past(target)); // R8

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && taken && slot_mode) |=> (pc == $past(pc) + 32'd4 && state_q == ST_SLOT)); // R9

    AST_SLOT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLOT) |=> (pc == $past(pend_q) && state_q == ST_RUN)); // R11

    AST_NO_SLOT_LINK: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLOT) |-> !link_we); // R10

    AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (rst)
        link_we |-> instr[XLEN-1 -: OP_W] == OPC_CALL); // R6

    AST_NEXT_MATCH: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pc == $past(next_pc)); // R12
endmodule

bind npc_unit npc_checks u_chk (
    .clk       (clk),
    .rst       (rst),
    .slot_mode (slot_mode),
    .instr     (instr),
    .pc        (pc),
    .next_pc   (next_pc),
    .link_we   (link_we),
    .state_q   (state_q),
    .pend_q    (pend_q),
    .taken     (taken),
    .target    (target)
);

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slot_mode = 1'b0;
    logic [31:0] instr = '0;
    logic        ops_equal = 1'b0;
    logic [31:0] rs_value = '0;
    logic [31:0] pc, next_pc, link_data;
    logic        link_we;
    logic [4:0]  link_reg;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    npc_unit u0 (
        .clk(clk), .rst(rst), .slot_mode(slot_mode), .instr(instr),
        .ops_equal(ops_equal), .rs_value(rs_value), .pc(pc), .next_pc(next_pc),
        .link_we(link_we), .link_data(link_data), .link_reg(link_reg)
    );

    typedef struct packed {
        logic        mode;
        logic [31:0] ins;
        logic        eq;
        logic [31:0] rs;
        logic [31:0] nxt;
        logic        lwe;
        logic [31:0] ldat;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        {1'b0, 32'h012A4020, 1'b0, 32'h0,        32'h00000004, 1'b0, 32'h0},        // R2 add
        {1'b0, 32'h10000019, 1'b1, 32'h0,        32'h0000006C, 1'b0, 32'h0},        // R3 taken
        {1'b0, 32'h10000019, 1'b0, 32'h0,        32'h00000070, 1'b0, 32'h0},        // R3 not taken
        {1'b0, 32'h1400FFFE, 1'b0, 32'h0,        32'h0000006C, 1'b0, 32'h0},        // R4 back
        {1'b0, 32'h1400FFFE, 1'b1, 32'h0,        32'h00000070, 1'b0, 32'h0},        // R4 not taken
        {1'b0, 32'h0C000040, 1'b0, 32'h0,        32'h00000100, 1'b1, 32'h00000074}, // R6 R8
        {1'b0, 32'h00000008, 1'b0, 32'h10000000, 32'h10000000, 1'b0, 32'h0},        // R7
        {1'b0, 32'h08000010, 1'b0, 32'h0,        32'h10000040, 1'b0, 32'h0},        // R5 region
        {1'b1, 32'h10000019, 1'b1, 32'h0,        32'h10000044, 1'b0, 32'h0},        // R9 slot
        {1'b1, 32'h0C000001, 1'b0, 32'h0,        32'h100000A8, 1'b0, 32'h0},        // R10 R9
        {1'b1, 32'h8E080018, 1'b1, 32'h0,        32'h100000AC, 1'b0, 32'h0},        // R2 load
        {1'b1, 32'h08000000, 1'b0, 32'h0,        32'h100000B0, 1'b0, 32'h0},        // R9 jump
        {1'b0, 32'h00000000, 1'b0, 32'h0,        32'h10000000, 1'b0, 32'h0},        // R11
        {1'b0, 32'h14000000, 1'b0, 32'h0,        32'h10000004, 1'b0, 32'h0},        // R4 zero ofs
        {1'b1, 32'h0C000003, 1'b0, 32'h0,        32'h10000008, 1'b1, 32'h10000008}, // R6 slot mode
        {1'b1, 32'h00000000, 1'b0, 32'h0,        32'h1000000C, 1'b0, 32'h0}         // R9 target
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset pc", pc, 32'h0);
        chk("R6 link_reg", {27'd0, link_reg}, 32'd31);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            slot_mode = VEC[i].mode;
            instr     = VEC[i].ins;
            ops_equal = VEC[i].eq;
            rs_value  = VEC[i].rs;
            #1;
            chk($sformatf("R12 next_pc vec %0d", i), next_pc, VEC[i].nxt);
            chk($sformatf("R6 R10 link_we vec %0d", i), {31'd0, link_we}, {31'd0, VEC[i].lwe});
            if (VEC[i].lwe)
                chk($sformatf("R6 link_data vec %0d", i), link_data, VEC[i].ldat);
            @(posedge clk);
            #1;
            chk($sformatf("R8 R9 pc vec %0d", i), pc, VEC[i].nxt);
            @(negedge clk);
        end
        // R1: reset in the slot cycle drops the pending target
        slot_mode = 1'b1; instr = 32'h10000019; ops_equal = 1'b1;
        @(posedge clk);
        @(negedge clk);
        instr = 32'h0; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 pc after reset", pc, 32'h0);
        rst = 1'b0;
        #1;
        chk("R1 pending cleared", next_pc, 32'h4);
        @(posedge clk);
        #1;
        chk("R1 R2 step after reset", pc, 32'h4);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule